// File: doc/BRIEF.md
# Iterative CORDIC Sine and Cosine Generator

This block turns an angle into its sine and cosine by rotation-mode CORDIC. One shift-add datapath is reused for every micro-rotation, one per clock, so the area is about one stage of an unrolled pipeline. The cost is that a new angle can only be taken once the previous result is out. The angle is an unsigned binary fraction of a full turn. Both results are signed Q1.15 values.

A caller presents an angle together with a one-cycle `start` while the unit is idle. The unit first folds the angle into the half-plane of positive cosine, so the iteration converges for any input, and then runs a fixed number of micro-rotations. It then rounds, restores the sign and saturates the two results, and pulses `done`. The X register starts at the reciprocal of the accumulated rotation gain, so the results need no correcting multiply.

Top module: `cordic_sincos`

## Requirements
- R1: The angle input is an unsigned fraction of a full turn, with 2^16 codes per 360 degrees. The outputs are two's-complement with 32768 meaning 1.0. For example, angle 0x1555 (30 degrees) gives a sine within 4 LSB of 16384 and a cosine within 4 LSB of 28378.
- R2: A `start` sampled high while idle latches `angle`. `busy` is high from the next cycle on, for exactly 16 consecutive cycles.
- R3: `done` goes high for exactly one cycle, one cycle after `busy` falls. That is 18 falling clock edges after the rising edge that accepted `start`.
- R4: `sine` and `cosine` change only when `done` rises. Changes on `angle` after acceptance, and between runs, have no effect on them.
- R5: A `start` that arrives while a run is in progress is ignored. The run ends at its original time with the result of the original angle, and no second run follows.
- R6: Angle bits 15:14 select the quadrant. Quadrants 1 and 2 (codes 0x4000 to 0xBFFF) are moved by half a turn into the range of plus or minus 90 degrees, and both results are negated. Every angle in the full circle gives a sine and cosine within 4 LSB of the rounded true values.
- R7: Results are saturated to the range -32768 to 32767 and never wrap. For example, angle 0x0000 gives a cosine of 32767 or just below, and angle 0x8000 gives a cosine near -32768.
- R8: After reset `busy` and `done` are low, and `sine` and `cosine` are zero.
- R9: The residual angle is driven toward zero with the direction taken from its sign only. After the last micro-rotation its magnitude is a few units of the finest arctangent step.
- R10: The number of micro-rotations is the same for every angle, including angles that reach a zero residual early, such as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion; sampled only while idle |
| angle | input | 16 | Angle, unsigned fraction of a full turn |
| busy | output | 1 | High during the micro-rotation cycles |
| done | output | 1 | One-cycle pulse when results are updated |
| sine | output | 16 | Sine, signed Q1.15, held until the next `done` |
| cosine | output | 16 | Cosine, signed Q1.15, held until the next `done` |

## Verification
The bench builds the block with its defaults: a 16-bit angle and 16-bit outputs, 16 micro-rotations, two high and four low guard bits in X and Y, and four fractional bits on the residual angle. With these values every quadrant boundary code is reachable, including 0x4000, 0x8000 and 0xC000 and the codes next to them. Both saturation corners can therefore be driven. The 16-cycle busy window is short enough to count exactly on every run.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // take a new angle, preset X/Y/Z
    logic step;     // one micro-rotation
    logic capture;  // register rounded outputs
  } cordic_strobe_t;

  // 1/gain of an infinite CORDIC chain, Q2.30
  localparam longint GAIN_Q30 = 64'd652032874;

  // atan(2^-n) as a fraction of a full turn, scaled by 2^24
  function automatic int atanTurn24(input int n);
    case (n)
      0: return 2097152;
      1: return 1238021;
      2: return 654136;
      3: return 332050;
      4: return 166669;
      5: return 83416;
      6: return 41718;
      7: return 20860;
      // small-angle region: atan(x) ~ x, 2^24/(2*pi) = 2670177
      default: return (n > 30) ? 0 : ((2670177 + (1 << (n - 1))) >> n);
    endcase
  endfunction

  // Same value on a 2^zw full-turn scale, rounded (zw <= 24)
  function automatic int atanScaled(input int n, input int zw);
    int rnd;
    rnd = (zw < 24) ? (1 << (23 - zw)) : 0;
    return (atanTurn24(n) + rnd) >> (24 - zw);
  endfunction

  // Reciprocal gain with frac fractional bits (frac <= 29)
  function automatic longint gainScaled(input int frac);
    return (GAIN_Q30 + (longint'(1) << (29 - frac))) >>> (30 - frac);
  endfunction

endpackage

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
  import cordic_pkg::*;
#(
  parameter int ITERS = 16,
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output cordic_strobe_t       strobes,
  output logic [IDX_W-1:0]     iterIdx,
  output logic                 busy,
  output logic                 done
);

  localparam int RUN_W = $clog2(ITERS + 2) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} ctrl_state_t;

  ctrl_state_t state;
  logic [IDX_W-1:0] iterCnt;
  logic lastIter;

  assign lastIter = (iterCnt == IDX_W'(ITERS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (lastIter) state <= ST_FINISH;
          else          iterCnt <= iterCnt + 1'b1;
        end
        ST_FINISH: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load    = (state == ST_IDLE) && start;
    strobes.step    = (state == ST_RUN);
    strobes.capture = (state == ST_FINISH);
  end

  assign iterIdx = iterCnt;
  assign busy    = (state == ST_RUN);

  // Length of the current busy window, for the checks below
  logic [RUN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  assert_start_to_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> busy);

  assert_busy_length_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == RUN_W'(ITERS)));

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |=> done);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath
  import cordic_pkg::*;
#(
  parameter int ANGLE_W  = 16,
  parameter int OUT_W    = 16,
  parameter int ITERS    = 16,
  parameter int IDX_W    = 4,
  parameter int GUARD_HI = 2,
  parameter int GUARD_LO = 4,
  parameter int ZFRAC    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cordic_strobe_t             strobes,
  input  logic [IDX_W-1:0]           iterIdx,
  input  logic [ANGLE_W-1:0]         angleIn,
  output logic signed [OUT_W-1:0]    sineOut,
  output logic signed [OUT_W-1:0]    cosineOut
);

  localparam int DW   = OUT_W + GUARD_HI + GUARD_LO;  // X/Y width
  localparam int ZW   = ANGLE_W + ZFRAC;              // residual angle width
  localparam int FRAC = OUT_W - 1 + GUARD_LO;         // X/Y fraction bits
  localparam int RW   = DW - GUARD_LO;                // rounded width
  localparam logic signed [DW-1:0] X_INIT    = DW'(gainScaled(FRAC));
  localparam logic signed [DW-1:0] ROUND_ADD = DW'(1) <<< (GUARD_LO - 1);
  localparam logic signed [RW-1:0] OUT_MAX   = RW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [RW-1:0] OUT_MIN   = -OUT_MAX - RW'(1);

  // Arctangent steps on the residual-angle scale
  logic signed [ZW-1:0] atanTab [ITERS];
  for (genvar i = 0; i < ITERS; i++) begin : g_atan
    assign atanTab[i] = ZW'(atanScaled(i, ZW));
  end

  logic signed [DW-1:0] xReg, yReg;
  logic signed [ZW-1:0] zReg;
  logic                 flipReg;

  // Quadrant fold: quadrants 1 and 2 move by half a turn
  logic               flipIn;
  logic [ANGLE_W-1:0] foldedAngle;
  assign flipIn      = angleIn[ANGLE_W-1] ^ angleIn[ANGLE_W-2];
  assign foldedAngle = angleIn ^ {flipIn, {(ANGLE_W-1){1'b0}}};

  // One micro-rotation
  logic signed [DW-1:0] xShift, yShift, xNext, yNext;
  logic signed [ZW-1:0] atanNow, zNext;
  logic                 zNeg;

  always_comb begin
    xShift  = xReg >>> iterIdx;
    yShift  = yReg >>> iterIdx;
    atanNow = atanTab[iterIdx];
    zNeg    = zReg[ZW-1];
    if (zNeg) begin
      xNext = xReg + yShift;
      yNext = yReg - xShift;
      zNext = zReg + atanNow;
    end else begin
      xNext = xReg - yShift;
      yNext = yReg + xShift;
      zNext = zReg - atanNow;
    end
  end

  // Sign restore, rounding, saturation
  function automatic logic signed [OUT_W-1:0] clipOut(input logic signed [RW-1:0] v);
    if (v > OUT_MAX)      return OUT_MAX[OUT_W-1:0];
    else if (v < OUT_MIN) return OUT_MIN[OUT_W-1:0];
    else                  return v[OUT_W-1:0];
  endfunction

  logic signed [DW-1:0] xSigned, ySigned, xRound, yRound;
  always_comb begin
    xSigned = flipReg ? -xReg : xReg;
    ySigned = flipReg ? -yReg : yReg;
    xRound  = xSigned + ROUND_ADD;
    yRound  = ySigned + ROUND_ADD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg      <= '0;
      yReg      <= '0;
      zReg      <= '0;
      flipReg   <= 1'b0;
      sineOut   <= '0;
      cosineOut <= '0;
    end else begin
      if (strobes.load) begin
        xReg    <= X_INIT;
        yReg    <= '0;
        zReg    <= {foldedAngle, {ZFRAC{1'b0}}};
        flipReg <= flipIn;
      end else if (strobes.step) begin
        xReg <= xNext;
        yReg <= yNext;
        zReg <= zNext;
      end
      if (strobes.capture) begin
        cosineOut <= clipOut(xRound[DW-1:GUARD_LO]);
        sineOut   <= clipOut(yRound[DW-1:GUARD_LO]);
      end
    end
  end

  // Checks on the residual angle
  localparam logic [ZW-1:0] Z_QUARTER = ZW'(1) << (ZW - 2);
  localparam logic [ZW-1:0] Z_BOUND   = ZW'(8 * atanScaled(ITERS - 1, ZW) + ITERS);
  logic [ZW-1:0] zMag;
  assign zMag = zReg[ZW-1] ? ZW'(-zReg) : ZW'(zReg);

  assert_fold_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (zMag <= Z_QUARTER));

  assert_residual_converged_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> (zMag <= Z_BOUND));

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
  import cordic_pkg::*;
#(
  parameter int ANGLE_W  = 16,
  parameter int OUT_W    = 16,
  parameter int ITERS    = 16,
  parameter int GUARD_HI = 2,
  parameter int GUARD_LO = 4,
  parameter int ZFRAC    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [ANGLE_W-1:0]      angle,
  output logic                    busy,
  output logic                    done,
  output logic signed [OUT_W-1:0] sine,
  output logic signed [OUT_W-1:0] cosine
);

  localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1;

  cordic_strobe_t   strobes;
  logic [IDX_W-1:0] iterIdx;

  cordic_ctrl #(
    .ITERS(ITERS),
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .start(start),
    .strobes(strobes),
    .iterIdx(iterIdx),
    .busy(busy),
    .done(done)
  );

  cordic_datapath #(
    .ANGLE_W(ANGLE_W),
    .OUT_W(OUT_W),
    .ITERS(ITERS),
    .IDX_W(IDX_W),
    .GUARD_HI(GUARD_HI),
    .GUARD_LO(GUARD_LO),
    .ZFRAC(ZFRAC)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .iterIdx(iterIdx),
    .angleIn(angle),
    .sineOut(sine),
    .cosineOut(cosine)
  );

  assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(sine) && $stable(cosine)));

  assert_hold_without_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(done) |-> ($stable(sine) && $stable(cosine)));

endmodule

// File: tb/cordic_sincos_test.sv
`timescale 1ns/1ps
module cordic_sincos_test;

  localparam real PI  = 3.14159265358979;
  localparam int  TOL = 4;
  localparam int  NVEC = 24;
  // Stimulus vectors: angles over all quadrants and boundaries (R6, R7, R9)
  localparam logic [15:0] ANGLES [NVEC] = '{
    16'h0000, 16'h0001, 16'h0800, 16'h1555, 16'h2000, 16'h2AAA,
    16'h3FFF, 16'h4000, 16'h4001, 16'h5555, 16'h6000, 16'h7000,
    16'h7FFF, 16'h8000, 16'h8001, 16'h9555, 16'hA000, 16'hBFFF,
    16'hC000, 16'hC001, 16'hD555, 16'hE000, 16'hF000, 16'hFFFF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] angle = '0;
  logic busy, done;
  logic signed [15:0] sine, cosine;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cordic_sincos uut (
    .clk(clk), .rstN(rstN), .start(start), .angle(angle),
    .busy(busy), .done(done), .sine(sine), .cosine(cosine)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int refVal(input logic [15:0] a, input bit wantSin);
    real th, v;
    int r;
    th = real'(a) * 2.0 * PI / 65536.0;
    v  = wantSin ? $sin(th) : $cos(th);
    r  = int'(v * 32768.0);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int absDiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Launch a run; count falling edges to done and busy cycles
  task automatic runOne(input logic [15:0] a, input int lateStartAt, input logic [15:0] lateAngle,
                        output int lat, output int busyN);
    @(negedge clk);
    angle = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    busyN = busy ? 1 : 0;
    while (!done && lat < 100) begin
      if (lat == lateStartAt) begin
        start = 1'b1;
        angle = lateAngle;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (busy) busyN++;
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int lat, busyN, s0, c0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(busy == 1'b0, "R8", "busy after reset", int'(busy), 0);
    check(done == 1'b0, "R8", "done after reset", int'(done), 0);
    check(sine == 0, "R8", "sine after reset", int'(sine), 0);
    check(cosine == 0, "R8", "cosine after reset", int'(cosine), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: accuracy in every quadrant (R6, R9), timing (R2, R3, R10)
    for (int i = 0; i < NVEC; i++) begin
      runOne(ANGLES[i], -1, '0, lat, busyN);
      check(lat == 18, "R3", $sformatf("latency angle %h", ANGLES[i]), lat, 18);
      check(busyN == 16, "R2", $sformatf("busy cycles angle %h", ANGLES[i]), busyN, 16);
      check(absDiff(int'(sine), refVal(ANGLES[i], 1'b1)) <= TOL, "R6",
            $sformatf("sine angle %h (R9)", ANGLES[i]), int'(sine), refVal(ANGLES[i], 1'b1));
      check(absDiff(int'(cosine), refVal(ANGLES[i], 1'b0)) <= TOL, "R6",
            $sformatf("cosine angle %h (R9)", ANGLES[i]), int'(cosine), refVal(ANGLES[i], 1'b0));
      @(negedge clk);
      check(done == 1'b0, "R3", "done single cycle", int'(done), 0);
    end

    // R1: 30 degrees
    runOne(16'h1555, -1, '0, lat, busyN);
    check(absDiff(int'(sine), 16384) <= TOL, "R1", "sine 30 deg", int'(sine), 16384);
    check(absDiff(int'(cosine), 28378) <= TOL, "R1", "cosine 30 deg", int'(cosine), 28378);

    // R10: zero angle still runs all micro-rotations
    runOne(16'h0000, -1, '0, lat, busyN);
    check(busyN == 16, "R10", "busy cycles for zero angle", busyN, 16);
    // R7: saturation without wrap
    check(cosine >= 32763, "R7", "cosine at 0 saturates high", int'(cosine), 32767);
    runOne(16'h4000, -1, '0, lat, busyN);
    check(sine >= 32763, "R7", "sine at 0x4000 saturates high", int'(sine), 32767);
    runOne(16'h8000, -1, '0, lat, busyN);
    check(cosine <= -32764, "R7", "cosine at 0x8000 near -32768", int'(cosine), -32768);
    runOne(16'hC000, -1, '0, lat, busyN);
    check(sine <= -32764, "R7", "sine at 0xC000 near -32768", int'(sine), -32768);

    // R4: angle changes after done leave outputs unchanged
    runOne(16'h2000, -1, '0, lat, busyN);
    s0 = int'(sine);
    c0 = int'(cosine);
    angle = 16'hA000;
    repeat (10) @(negedge clk);
    check(int'(sine) == s0, "R4", "sine held after angle change", int'(sine), s0);
    check(int'(cosine) == c0, "R4", "cosine held after angle change", int'(cosine), c0);
    check(done == 1'b0, "R4", "no done without start", int'(done), 0);

    // R5: start during a run is ignored
    runOne(16'h1000, 5, 16'h9000, lat, busyN);
    check(lat == 18, "R5", "latency with start mid-run", lat, 18);
    check(absDiff(int'(sine), refVal(16'h1000, 1'b1)) <= TOL, "R5", "sine of original angle",
          int'(sine), refVal(16'h1000, 1'b1));
    check(absDiff(int'(cosine), refVal(16'h1000, 1'b0)) <= TOL, "R5", "cosine of original angle",
          int'(cosine), refVal(16'h1000, 1'b0));
    begin
      int extra = 0;
      repeat (20) begin
        @(negedge clk);
        if (busy || done) extra++;
      end
      check(extra == 0, "R5", "no second run after ignored start", extra, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule